// File: doc/BRIEF.md
# Dual-Path Event Detector with Debounce

The block watches two external inputs and raises a shared interrupt when either one sees a qualifying event. The fast input is synchronized and its rising edges are counted against a programmable threshold. When the count is reached, a sticky fast-path flag is set. The slow input is meant for a mechanical switch to ground. It is synchronized and then debounced against a timebase tick, and a stable move to the active (low) level sets a sticky slow-path flag.

Software reaches the block through a small register port. Writes are sampled on the clock edge, and reads are combinational from the read address. Through that port software picks which paths run, sets the debounce length, loads the threshold and clears the flags. An override bit takes the fast input away from event counting. Every edge on that input then becomes a one-cycle watchdog-clear pulse.

Register map: address 0 is control, address 1 is the threshold, address 2 is status with write-1-to-clear flags, and address 3 reads as zero.

Top module: `evdet_top`

## Requirements
- R1: Control bits [1:0] select the running paths. 00 runs neither path, 01 runs only the slow path (bit 0), 10 runs only the fast path (bit 1), and 11 runs both. A path that is not running never sets its flag.
- R2: While the fast path runs, each rising edge of `hs_in` adds one to a count. The count reaching the threshold (address 1) sets status bit 0. Falling edges are not counted.
- R3: A threshold of 0 acts as a threshold of 1, so a single rising edge sets status bit 0.
- R4: With control bit 2 at 0, `ls_in` must differ from its accepted level for 1024 consecutive ticks before the new level is accepted. Acceptance of the low level sets status bit 1. A shorter excursion has no effect.
- R5: With control bit 2 at 1, the required hold time is 16384 ticks.
- R6: Each flag stays set until software writes 1 to its status bit at address 2. `irq` is high whenever either flag is set and low once both are clear.
- R7: With control bit 3 set, every rising or falling edge on `hs_in` produces a one-cycle `wdt_clr` pulse. Such edges are not counted and never set status bit 0, whatever the enable field holds. `wdt_clr` stays low while bit 3 is clear.
- R8: When a flag is set and cleared by software in the same cycle, the set wins and the flag stays 1.
- R9: After reset, control, threshold and status read as 0, and `irq` and `wdt_clr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Debounce timebase enable, one count per high cycle |
| hs_in | input | 1 | Fast event input, asynchronous |
| ls_in | input | 1 | Switch input, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Interrupt, high while any flag is set |
| wdt_clr | output | 1 | Watchdog-clear pulse from fast-input edges under override |

## Verification
The collision that matters is a software write clearing the slow-path flag in the same cycle as the debouncer accepts a new press.

To provoke it, the flag is first left set from an earlier press and the switch is released until the high level is accepted. The switch is then pressed again, and the clearing write is timed to land on the exact edge where the 1024-tick hold completes. Status is read afterwards and must still show the flag. A second, isolated write must then clear it and drop `irq`.

// File: rtl/evdet_pkg.sv
package evdet_pkg;
   localparam int REG_AW = 2;
   localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
   localparam logic [REG_AW-1:0] ADDR_THR  = 2'd1;
   localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;

   // bit order is behaviour: the enable encoding uses bit 0 = slow, bit 1 = fast
   typedef struct packed {
      logic ovr;      // 3: fast pin feeds watchdog clear
      logic db_long;  // 2: long debounce window
      logic en_hs;    // 1: fast path runs
      logic en_ls;    // 0: slow path runs
   } ctrl_t;

   localparam int STAT_HS_BIT = 0;
   localparam int STAT_LS_BIT = 1;
endpackage

// File: rtl/evdet_sync.sv
module evdet_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("evdet_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sr;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= RST_VAL;
         else        sr <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= {STAGES{RST_VAL}};
         else        sr <= {sr[STAGES-2:0], d};
      end
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/evdet_hs_path.sv
module evdet_hs_path #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hs_sync,
   input  logic             en,
   input  logic             ovr,
   input  logic [CNT_W-1:0] thr,
   input  logic             clr,
   output logic             flag,
   output logic             wdt_clr
);
   logic             hs_d;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] thr_eff;
   logic [CNT_W:0]   cnt_nxt;
   logic             rise, any_edge, counting, hit;

   assign any_edge = hs_sync ^ hs_d;
   assign rise     = hs_sync & ~hs_d;
   assign thr_eff  = (thr == '0) ? CNT_W'(1) : thr;
   assign cnt_nxt  = {1'b0, cnt} + (CNT_W+1)'(1);
   assign counting = en & ~ovr & ~flag;
   assign hit      = counting & rise & (cnt_nxt >= {1'b0, thr_eff});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_d    <= 1'b0;
         wdt_clr <= 1'b0;
      end else begin
         hs_d    <= hs_sync;
         wdt_clr <= ovr & any_edge;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!en || ovr || clr) cnt <= '0;
      else if (hit)              cnt <= '0;
      else if (counting && rise) cnt <= cnt_nxt[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (hit)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end
endmodule

// File: rtl/evdet_ls_path.sv
module evdet_ls_path #(
   parameter int DB_SHORT   = 1024,
   parameter int DB_LONG    = 16384,
   parameter bit ACTIVE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ls_sync,
   input  logic tick,
   input  logic en,
   input  logic db_long,
   input  logic clr,
   output logic flag
);
   localparam int CW = (DB_LONG > 2) ? $clog2(DB_LONG) : 1;
   localparam logic [CW-1:0] LIM_S = CW'(DB_SHORT - 1);
   localparam logic [CW-1:0] LIM_L = CW'(DB_LONG - 1);

   logic          stable;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic          differ, accept, fire;

   assign lim    = db_long ? LIM_L : LIM_S;
   assign differ = ls_sync != stable;
   assign accept = en & differ & tick & (cnt >= lim);
   assign fire   = accept & (ls_sync == ACTIVE_LVL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stable <= ~ACTIVE_LVL;
         cnt    <= '0;
      end else if (!en) begin
         stable <= ls_sync;
         cnt    <= '0;
      end else if (!differ) begin
         cnt    <= '0;
      end else if (accept) begin
         stable <= ls_sync;
         cnt    <= '0;
      end else if (tick) begin
         cnt    <= cnt + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (fire) flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end
endmodule

// File: rtl/evdet_top.sv
module evdet_top
   import evdet_pkg::*;
#(
   parameter int DW          = 8,
   parameter int THR_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DB_SHORT    = 1024,
   parameter int DB_LONG     = 16384,
   parameter bit LS_ACTIVE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hs_in,
   input  logic              ls_in,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic              irq,
   output logic              wdt_clr
);
   localparam int CTRL_W = $bits(ctrl_t);

   if (DW < CTRL_W) begin : g_bad_dw
      $error("evdet_top: DW too narrow for control");
   end
   if (THR_W < 1 || THR_W > DW) begin : g_bad_thr
      $error("evdet_top: THR_W out of range");
   end
   if (DB_SHORT < 2 || DB_LONG <= DB_SHORT) begin : g_bad_db
      $error("evdet_top: debounce windows inconsistent");
   end

   ctrl_t            ctrl_q;
   logic [THR_W-1:0] thr_q;
   logic             hs_sync, ls_sync;
   logic             hs_flag, ls_flag;
   logic             stat_wr, hs_clr, ls_clr;

   assign stat_wr = wr_en && (wr_addr == ADDR_STAT);
   assign hs_clr  = stat_wr && wr_data[STAT_HS_BIT];
   assign ls_clr  = stat_wr && wr_data[STAT_LS_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         thr_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_addr == ADDR_THR)  thr_q  <= wr_data[THR_W-1:0];
      end
   end

   evdet_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hs_sync (
      .clk(clk), .rst_n(rst_n), .d(hs_in), .q(hs_sync)
   );

   evdet_sync #(.STAGES(SYNC_STAGES), .RST_VAL(~LS_ACTIVE)) u_ls_sync (
      .clk(clk), .rst_n(rst_n), .d(ls_in), .q(ls_sync)
   );

   evdet_hs_path #(.CNT_W(THR_W)) u_hs (
      .clk(clk), .rst_n(rst_n), .hs_sync(hs_sync),
      .en(ctrl_q.en_hs), .ovr(ctrl_q.ovr), .thr(thr_q),
      .clr(hs_clr), .flag(hs_flag), .wdt_clr(wdt_clr)
   );

   evdet_ls_path #(.DB_SHORT(DB_SHORT), .DB_LONG(DB_LONG), .ACTIVE_LVL(LS_ACTIVE)) u_ls (
      .clk(clk), .rst_n(rst_n), .ls_sync(ls_sync), .tick(tick),
      .en(ctrl_q.en_ls), .db_long(ctrl_q.db_long),
      .clr(ls_clr), .flag(ls_flag)
   );

   assign irq = hs_flag | ls_flag;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
         ADDR_THR:  rd_data[THR_W-1:0]  = thr_q;
         ADDR_STAT: begin
            rd_data[STAT_HS_BIT] = hs_flag;
            rd_data[STAT_LS_BIT] = ls_flag;
         end
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/evdet_checker.sv
module evdet_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic [3:0] ctrl_bits,
   input logic       hs_flag,
   input logic       ls_flag,
   input logic       irq,
   input logic       wdt_clr
);
   // R6: the interrupt drops only after a status write
   assert_irq_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en && wr_addr == 2'd2));

   // R7: watchdog-clear pulses need the override bit
   assert_wdt_needs_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |-> $past(ctrl_bits[3]));

   // R1: fast flag sets only with fast enable and no override
   assert_hs_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_flag) |-> $past(ctrl_bits[1] && !ctrl_bits[3]));

   // R1: slow flag sets only with slow enable
   assert_ls_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_flag) |-> $past(ctrl_bits[0]));
endmodule

bind evdet_top evdet_checker u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .ctrl_bits(ctrl_q), .hs_flag(hs_flag), .ls_flag(ls_flag),
   .irq(irq), .wdt_clr(wdt_clr)
);

// File: tb/evdet_top_tb.sv
`timescale 1ns/100ps
module evdet_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       hs_in = 1'b0;
   logic       ls_in = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq, wdt_clr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evdet_top u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hs_in(hs_in), .ls_in(ls_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wdt_clr(wdt_clr)
   );

   // sel: 0 irq, 1 wdt_clr, 2 rd_data
   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t exp_q[$];
   event  chk_ev;

   always @(chk_ev) begin
      while (exp_q.size() > 0) begin
         item_t it;
         logic [7:0] got;
         it = exp_q.pop_front();
         case (it.sel)
            0:       got = {7'd0, irq};
            1:       got = {7'd0, wdt_clr};
            default: got = rd_data;
         endcase
         checks++;
         if (got !== it.exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", it.tag, got, it.exp);
         end
      end
   end

   task automatic expect_v(input int sel, input logic [7:0] exp, input string tag);
      item_t it;
      it.sel = sel; it.exp = exp; it.tag = tag;
      exp_q.push_back(it);
      -> chk_ev;
      #0.1;
   endtask

   task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
      rd_addr = a;
      #0.1;
      expect_v(2, exp, tag);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic pulse_hs();
      hs_in = 1'b1; step(3);
      hs_in = 1'b0; step(3);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      // R9 reset state
      expect_reg(2'd0, 8'h00, "R9 ctrl");
      expect_reg(2'd1, 8'h00, "R9 thr");
      expect_reg(2'd2, 8'h00, "R9 stat");
      expect_v(0, 8'h00, "R9 irq");
      expect_v(1, 8'h00, "R9 wdt_clr");

      // R2 fast path, threshold 3
      wr(2'd0, 8'h02);
      wr(2'd1, 8'h03);
      pulse_hs(); pulse_hs();
      expect_reg(2'd2, 8'h00, "R2 two edges below threshold");
      expect_v(1, 8'h00, "R7 no wdt_clr without override");
      pulse_hs();
      expect_reg(2'd2, 8'h01, "R2 threshold reached");
      expect_v(0, 8'h01, "R6 irq with fast flag");

      // R3 threshold zero, R6 clear
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h01);
      expect_reg(2'd2, 8'h00, "R6 fast flag cleared");
      expect_v(0, 8'h00, "R6 irq released");
      hs_in = 1'b1; step(4);
      expect_reg(2'd2, 8'h01, "R3 zero threshold acts as one");
      wr(2'd2, 8'h01);
      hs_in = 1'b0; step(4);
      expect_reg(2'd2, 8'h00, "R2 falling edge not counted");

      // R1 slow only; R4 glitch and press
      wr(2'd0, 8'h01);
      pulse_hs();
      expect_reg(2'd2, 8'h00, "R1 fast path off under 01");
      ls_in = 1'b0; step(500);
      ls_in = 1'b1; step(1100);
      expect_reg(2'd2, 8'h00, "R4 short glitch ignored");
      ls_in = 1'b0; step(1022);
      expect_reg(2'd2, 8'h00, "R4 before hold time");
      step(8);
      expect_reg(2'd2, 8'h02, "R4 press accepted");
      expect_v(0, 8'h01, "R6 irq with slow flag");

      // R8 collision of set and clear
      ls_in = 1'b1; step(1100);
      ls_in = 1'b0; step(1025);
      wr(2'd2, 8'h02);
      expect_reg(2'd2, 8'h02, "R8 set wins over clear");
      wr(2'd2, 8'h02);
      expect_reg(2'd2, 8'h00, "R6 slow flag cleared");
      expect_v(0, 8'h00, "R6 irq released after slow clear");
      ls_in = 1'b1; step(1100);

      // R5 long debounce
      wr(2'd0, 8'h05);
      ls_in = 1'b0; step(1100);
      expect_reg(2'd2, 8'h00, "R5 short window not enough");
      step(15300);
      expect_reg(2'd2, 8'h02, "R5 long window accepted");
      wr(2'd2, 8'h02);
      ls_in = 1'b1; step(16400);

      // R1 both off
      wr(2'd0, 8'h00);
      ls_in = 1'b0; step(1100);
      pulse_hs();
      expect_reg(2'd2, 8'h00, "R1 both paths off under 00");
      expect_v(0, 8'h00, "R1 irq low under 00");
      ls_in = 1'b1; step(10);

      // R1 both on, R6 partial clear
      wr(2'd0, 8'h03);
      wr(2'd1, 8'h01);
      ls_in = 1'b0; step(1100);
      pulse_hs();
      expect_reg(2'd2, 8'h03, "R1 both flags under 11");
      wr(2'd2, 8'h01);
      expect_reg(2'd2, 8'h02, "R6 only fast flag cleared");
      expect_v(0, 8'h01, "R6 irq held by slow flag");
      wr(2'd2, 8'h02);
      expect_v(0, 8'h00, "R6 irq low after both cleared");
      ls_in = 1'b1; step(1100);

      // R7 override
      wr(2'd0, 8'h08);
      hs_in = 1'b1; step(3);
      expect_v(1, 8'h01, "R7 pulse on rising edge");
      step(1);
      expect_v(1, 8'h00, "R7 pulse is one cycle");
      step(4);
      wr(2'd0, 8'h0A);
      hs_in = 1'b0; step(3);
      expect_v(1, 8'h01, "R7 pulse on falling edge");
      step(5);
      expect_reg(2'd2, 8'h00, "R7 override edges not counted");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired got=running exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule